// File: doc/BRIEF.md
# Split TLB Invalidation Controller

This block holds two small address-translation caches: one for instruction fetches and one for data accesses. Each entry stores a virtual page number, a valid bit and a lock bit. The lock bit shields the entry from bulk clearing. The translation tables themselves are walked elsewhere. That logic loads entries through a fill port and asks whether a page is present through a lookup port.

Maintenance software writes commands to the block. A command carries a 4-bit minor selector, a 3-bit operation selector and a 32-bit data word. The block decodes the selectors into one of five invalidations. It then sweeps the targeted cache or caches, one entry per clock, with `busy` high for the whole sweep. A new command is held off through a ready/valid handshake until the sweep ends.

A read attempt is rejected, and so is any selector pair that is not defined. Either one starts no sweep and raises a one-cycle `unpred` pulse.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset every entry of both caches is invalid, so no lookup hits. `busy` and `unpred` are 0 and `cmd_ready` is 1.
- R2: The selector pairs (minor, op) decode as follows:
  - (7,0) clears both caches in bulk.
  - (5,0) clears the instruction cache in bulk.
  - (6,0) clears the data cache in bulk.
  - (5,1) clears matching entries of the instruction cache by address.
  - (6,1) clears matching entries of the data cache by address.
  - A cache that the command does not target is left unchanged.
- R3: A bulk clear invalidates only entries whose lock bit is 0. Locked entries stay valid with their tags.
- R4: A clear by address invalidates every valid entry of the targeted cache whose page number equals `cmd_data[31:10]`, whatever its lock bit. Entries with other page numbers are untouched.
- R5: For bulk clears the value of `cmd_data` has no effect.
- R6: For clears by address, `cmd_data[9:0]` takes no part in the match.
- R7: A command accepted with `cmd_read`=1, or with any selector pair not listed in R2, changes no entry, starts no sweep and drives `unpred` high for exactly the one cycle after acceptance.
- R8: A defined command accepted on a clock edge raises `busy` for the next 8 cycles. `cmd_ready` equals the inverse of `busy`, so commands presented while busy wait.
- R9: A fill writes page number, valid bit and lock bit to the chosen entry (`fill_sel_d`=1 for the data cache). A lookup reports a hit and the lowest matching valid entry index. It never matches an invalid entry.
- R10: A fill aimed at the entry that the sweep visits in the same cycle is dropped. The entry keeps its previous tag, and the sweep decides its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_read | input | 1 | Command is a read attempt |
| cmd_minor | input | 4 | Minor selector |
| cmd_op | input | 3 | Operation selector |
| cmd_data | input | 32 | Data word; page number in bits 31:10 |
| busy | output | 1 | Sweep in progress |
| unpred | output | 1 | One-cycle pulse for a rejected command |
| fill_en | input | 1 | Write one entry |
| fill_sel_d | input | 1 | 1 selects the data cache |
| fill_idx | input | 3 | Entry index |
| fill_vpn | input | 22 | Page number to store |
| fill_valid | input | 1 | Valid bit to store |
| fill_lock | input | 1 | Lock bit to store |
| lk_sel_d | input | 1 | 1 looks up the data cache |
| lk_vpn | input | 22 | Page number to look up |
| lk_hit | output | 1 | A valid entry matches |
| lk_idx | output | 3 | Lowest matching entry |

## Verification
Random fills draw page numbers from a pool of 16 values, so duplicate and matching tags occur often. They mix locked and unlocked entries. Random commands are then drawn from the five defined pairs, near-miss pairs and reads, with random data words.

Each command is followed by a lookup of every pool page in both caches. This separates four cases:
- bulk clears from clears by address;
- locked from unlocked handling;
- which cache was targeted;
- whether the low data bits leaked into the match.

Directed cases cover the reset state, the exact length of `busy`, a fill colliding with the sweep, and a clear by address that hits a locked entry.

// File: rtl/tlbinv_pkg.sv
// Shared definitions for the split TLB invalidation controller.
// Assumes addresses are 32 bits with 1 KiB-granular page numbers.
package tlbinv_pkg;
    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 10;
    localparam int VPN_W    = ADDR_W - PAGE_LSB;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BOTH_ALL,
        OP_I_ALL,
        OP_I_ONE,
        OP_D_ALL,
        OP_D_ONE
    } inv_op_t;
endpackage

// File: rtl/tlb_cmd_decode.sv
// Decodes the command selectors into one invalidation kind.
// Assumes cmd_read marks an illegal read attempt; anything undefined yields OP_NONE.
module tlb_cmd_decode
    import tlbinv_pkg::*;
(
    input  logic       rd,
    input  logic [3:0] minor,
    input  logic [2:0] op,
    output inv_op_t    kind
);
    // Map the selector pair onto an operation.
    always_comb begin
        kind = OP_NONE;
        if (!rd) begin
            unique case ({minor, op})
                {4'd7, 3'd0}: kind = OP_BOTH_ALL;
                {4'd5, 3'd0}: kind = OP_I_ALL;
                {4'd5, 3'd1}: kind = OP_I_ONE;
                {4'd6, 3'd0}: kind = OP_D_ALL;
                {4'd6, 3'd1}: kind = OP_D_ONE;
                default:      kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/tlb_sweep.sv
// Walks entry indices 0..N-1, one per cycle, after a start pulse.
// Assumes start only arrives while idle (the top gates it with ready).
module tlb_sweep #(
    parameter int N     = 8,
    parameter int VPN_W = 22,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_i,
    input  logic             start_d,
    input  logic             start_one,
    input  logic [VPN_W-1:0] start_vpn,
    output logic             busy,
    output logic             inv_i_en,
    output logic             inv_d_en,
    output logic             inv_one,
    output logic [IW-1:0]    inv_idx,
    output logic [VPN_W-1:0] inv_vpn
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic tgt_i, tgt_d;

    // Latch the command at start and step the index until the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            inv_idx <= '0;
            tgt_i   <= 1'b0;
            tgt_d   <= 1'b0;
            inv_one <= 1'b0;
            inv_vpn <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            inv_idx <= '0;
            tgt_i   <= start_i;
            tgt_d   <= start_d;
            inv_one <= start_one;
            inv_vpn <= start_vpn;
        end else if (busy) begin
            if (inv_idx == LAST) busy <= 1'b0;
            else                 inv_idx <= inv_idx + 1'b1;
        end
    end

    assign inv_i_en = busy && tgt_i;
    assign inv_d_en = busy && tgt_d;

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && inv_idx == LAST && !start) |=> !busy); // R8
    AST_SWEEP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && inv_idx != LAST) |=> (busy && inv_idx == $past(inv_idx) + 1'b1)); // R8
endmodule

// File: rtl/tlb_bank.sv
// One TLB: N entries with valid, lock and page tag, plus fill, lookup and
// per-entry invalidation. A sweep visit to an entry overrides a fill to it.
module tlb_bank #(
    parameter int N     = 8,
    parameter int VPN_W = 22,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_en,
    input  logic             inv_one,
    input  logic [IW-1:0]    inv_idx,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             fill_en,
    input  logic [IW-1:0]    fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_valid,
    input  logic             fill_lock,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_idx
);
    logic [N-1:0]            ent_v;
    logic [N-1:0]            ent_l;
    logic [N-1:0][VPN_W-1:0] ent_t;
    logic [N-1:0]            lk_match;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic visit, fill_me, kill;
        assign visit   = inv_en && (inv_idx == IW'(g));
        assign fill_me = fill_en && (fill_idx == IW'(g));
        assign kill    = visit && (inv_one ? (ent_t[g] == inv_vpn) : !ent_l[g]);

        // Update one entry: reset, sweep visit, or fill, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_v[g] <= 1'b0;
                ent_l[g] <= 1'b0;
                ent_t[g] <= '0;
            end else if (visit) begin
                if (kill) ent_v[g] <= 1'b0;
            end else if (fill_me) begin
                ent_v[g] <= fill_valid;
                ent_l[g] <= fill_lock;
                ent_t[g] <= fill_vpn;
            end
        end

        assign lk_match[g] = ent_v[g] && (ent_t[g] == lk_vpn);

        AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (visit && !inv_one && ent_l[g] && ent_v[g]) |=> ent_v[g]); // R3
        AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
            (visit && fill_me) |=> $stable(ent_t[g])); // R10
        AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (visit && inv_one && ent_t[g] == inv_vpn) |=> !ent_v[g]); // R4
    end

    // Report the lowest-index valid match.
    always_comb begin
        lk_hit = |lk_match;
        lk_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (lk_match[i]) lk_idx = IW'(i);
    end

    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ent_v[lk_idx]); // R9
endmodule

// File: rtl/tlb_inval_ctrl.sv
// Top: command decode, handshake, sweep sequencer and the two TLB banks.
// Assumes the data word carries the page number in its upper bits.
module tlb_inval_ctrl
    import tlbinv_pkg::*;
#(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_read,
    input  logic [3:0]       cmd_minor,
    input  logic [2:0]       cmd_op,
    input  logic [ADDR_W-1:0] cmd_data,
    output logic             busy,
    output logic             unpred,
    input  logic             fill_en,
    input  logic             fill_sel_d,
    input  logic [IW-1:0]    fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_valid,
    input  logic             fill_lock,
    input  logic             lk_sel_d,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_idx
);
    inv_op_t          kind;
    logic             accept, start;
    logic             inv_i_en, inv_d_en, inv_one;
    logic [IW-1:0]    inv_idx;
    logic [VPN_W-1:0] inv_vpn;
    logic             i_hit, d_hit;
    logic [IW-1:0]    i_idx, d_idx;
    logic             unused_low;

    assign unused_low = ^cmd_data[PAGE_LSB-1:0];

    tlb_cmd_decode u_dec (.rd(cmd_read), .minor(cmd_minor), .op(cmd_op), .kind(kind));

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign start     = accept && (kind != OP_NONE);

    // Flag a rejected command for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) unpred <= 1'b0;
        else        unpred <= accept && (kind == OP_NONE);
    end

    tlb_sweep #(.N(N), .VPN_W(VPN_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_i(kind == OP_BOTH_ALL || kind == OP_I_ALL || kind == OP_I_ONE),
        .start_d(kind == OP_BOTH_ALL || kind == OP_D_ALL || kind == OP_D_ONE),
        .start_one(kind == OP_I_ONE || kind == OP_D_ONE),
        .start_vpn(cmd_data[ADDR_W-1:PAGE_LSB]),
        .busy(busy), .inv_i_en(inv_i_en), .inv_d_en(inv_d_en),
        .inv_one(inv_one), .inv_idx(inv_idx), .inv_vpn(inv_vpn));

    tlb_bank #(.N(N), .VPN_W(VPN_W)) u_itlb (
        .clk(clk), .rst_n(rst_n), .inv_en(inv_i_en), .inv_one(inv_one),
        .inv_idx(inv_idx), .inv_vpn(inv_vpn), .fill_en(fill_en && !fill_sel_d),
        .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_valid(fill_valid),
        .fill_lock(fill_lock), .lk_vpn(lk_vpn), .lk_hit(i_hit), .lk_idx(i_idx));

    tlb_bank #(.N(N), .VPN_W(VPN_W)) u_dtlb (
        .clk(clk), .rst_n(rst_n), .inv_en(inv_d_en), .inv_one(inv_one),
        .inv_idx(inv_idx), .inv_vpn(inv_vpn), .fill_en(fill_en && fill_sel_d),
        .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_valid(fill_valid),
        .fill_lock(fill_lock), .lk_vpn(lk_vpn), .lk_hit(d_hit), .lk_idx(d_idx));

    assign lk_hit = lk_sel_d ? d_hit : i_hit;
    assign lk_idx = lk_sel_d ? d_idx : i_idx;

    AST_REJECT_NO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |-> !busy); // R7
    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && !cmd_read)); // R8
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !unpred); // R8
endmodule

// File: tb/tlb_inval_ctrl_test.sv
module tlb_inval_ctrl_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, cmd_read = 0;
    logic [3:0]  cmd_minor = 0;
    logic [2:0]  cmd_op = 0;
    logic [31:0] cmd_data = 0;
    logic        cmd_ready, busy, unpred;
    logic        fill_en = 0, fill_sel_d = 0, fill_valid = 0, fill_lock = 0;
    logic [2:0]  fill_idx = 0;
    logic [21:0] fill_vpn = 0;
    logic        lk_sel_d = 0;
    logic [21:0] lk_vpn = 0;
    logic        lk_hit;
    logic [2:0]  lk_idx;

    always #2 clk = ~clk;

    tlb_inval_ctrl uut (.*);

    int checks = 0, fails = 0;
    int unsigned cyc = 0;

    logic        m_v [2][N];
    logic        m_l [2][N];
    logic [21:0] m_t [2][N];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] pool(int k);
        return 22'h1000 + 22'(k * 37);
    endfunction

    function automatic logic [3:0] exp_lk(int s, logic [21:0] t);
        for (int i = 0; i < N; i++)
            if (m_v[s][i] && m_t[s][i] == t) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    function automatic int kind_of(logic rd, logic [3:0] mi, logic [2:0] op);
        if (rd) return 0;
        if (mi == 7 && op == 0) return 1;
        if (mi == 5 && op == 0) return 2;
        if (mi == 5 && op == 1) return 3;
        if (mi == 6 && op == 0) return 4;
        if (mi == 6 && op == 1) return 5;
        return 0;
    endfunction

    function automatic void model_apply(int k, logic [31:0] d);
        for (int s = 0; s < 2; s++) begin
            bit tgt = (k == 1) || (s == 0 && (k == 2 || k == 3)) || (s == 1 && (k == 4 || k == 5));
            bit one = (k == 3 || k == 5);
            if (tgt)
                for (int i = 0; i < N; i++)
                    if (one ? (m_t[s][i] == d[31:10]) : !m_l[s][i]) m_v[s][i] = 1'b0;
        end
    endfunction

    task automatic fill(int s, int idx, logic [21:0] t, logic v, logic l);
        @(negedge clk);
        fill_en = 1; fill_sel_d = s[0]; fill_idx = 3'(idx);
        fill_vpn = t; fill_valid = v; fill_lock = l;
        @(negedge clk);
        fill_en = 0;
        m_v[s][idx] = v; m_l[s][idx] = l; m_t[s][idx] = t;
    endtask

    task automatic verify_all(string req);
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 16; k++) begin
                lk_sel_d = s[0]; lk_vpn = pool(k);
                #0.5;
                chk(req, {lk_hit, lk_idx}, exp_lk(s, pool(k)));
            end
    endtask

    task automatic command(logic rd, logic [3:0] mi, logic [2:0] op, logic [31:0] d);
        int k = kind_of(rd, mi, op);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_read = rd; cmd_minor = mi; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0; cmd_read = 0;
        chk("R7 unpred pulse", unpred, (k == 0));
        chk("R8 busy after accept", busy, (k != 0));
        if (k != 0) begin
            chk("R8 ready low while busy", cmd_ready, 0);
            repeat (7) @(negedge clk);
            chk("R8 busy still high on cycle 8", busy, 1);
            @(negedge clk);
            chk("R8 busy falls after 8", busy, 0);
        end else begin
            @(negedge clk);
            chk("R7 unpred one cycle", unpred, 0);
        end
        model_apply(k, d);
    endtask

    initial begin
        int unused_seed = $urandom(32'd1234);
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin m_v[s][i] = 0; m_l[s][i] = 0; m_t[s][i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 unpred", unpred, 0);
        chk("R1 ready", cmd_ready, 1);
        verify_all("R1 empty after reset");

        // R9: fill, lowest-index hit, invalid fill not matched
        fill(0, 5, pool(3), 1, 0);
        fill(0, 2, pool(3), 1, 0);
        fill(0, 1, pool(3), 0, 0);
        fill(1, 7, pool(4), 1, 1);
        verify_all("R9 fill and lookup");

        // R4: single clear removes a locked data entry; R6 low bits ignored
        command(0, 6, 1, {pool(4), 10'h3ff});
        verify_all("R4 R6 single clear of locked entry");

        // R3 R5: bulk clear with junk data keeps locked entry
        fill(0, 0, pool(8), 1, 1);
        command(0, 5, 0, 32'hdead_beef);
        verify_all("R3 R5 bulk clear spares locked");

        // R7: read attempt and undefined pair change nothing
        fill(1, 3, pool(9), 1, 0);
        command(1, 6, 0, 0);
        command(0, 7, 1, 0);
        verify_all("R7 rejected commands");

        // R10: fill colliding with the sweep visit of entry 0
        fill(1, 0, pool(10), 1, 1);
        @(negedge clk);
        cmd_valid = 1; cmd_minor = 6; cmd_op = 0; cmd_data = 0;
        @(negedge clk);
        cmd_valid = 0;
        fill_en = 1; fill_sel_d = 1; fill_idx = 0; fill_vpn = pool(11);
        fill_valid = 1; fill_lock = 0;
        @(negedge clk);
        fill_en = 0;
        repeat (8) @(negedge clk);
        model_apply(4, 0);
        verify_all("R10 fill dropped during visit");

        // R2 R3 R4 R6: random mix
        for (int it = 0; it < 60; it++) begin
            int nf = $urandom_range(1, 6);
            int pick;
            for (int f = 0; f < nf; f++)
                fill($urandom_range(0, 1), $urandom_range(0, N - 1), pool($urandom_range(0, 15)),
                     1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 2) == 0));
            pick = $urandom_range(0, 8);
            case (pick)
                0: command(0, 7, 0, $urandom);
                1: command(0, 5, 0, $urandom);
                2: command(0, 5, 1, {pool($urandom_range(0, 15)), 10'($urandom)});
                3: command(0, 6, 0, $urandom);
                4: command(0, 6, 1, {pool($urandom_range(0, 15)), 10'($urandom)});
                5: command(1, 4'($urandom_range(5, 7)), 3'($urandom_range(0, 1)), $urandom);
                6: command(0, 4'($urandom), 3'($urandom_range(2, 7)), $urandom);
                7: command(0, 4'($urandom_range(0, 4)), 3'($urandom_range(0, 1)), $urandom);
                default: command(0, 7, 0, 0);
            endcase
            verify_all("R2 R3 R4 R6 random command");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule